// File: doc/BRIEF.md
# Strobe-Interface Sampling Converter Host Controller

This block sits on the host side of an 8-bit sampling converter that is controlled through active-low strobes: a chip select, a write strobe and a read strobe. A user pulses a request while the controller is idle. The controller then runs one acquisition and hands back the byte with a single-cycle valid pulse. If the converter does not respond in time, it raises an error pulse instead.

Two sequences are supported, and `mode_rd_i` picks one when the request is taken. In write-start sequencing the controller lowers chip select and pulses write low to start a conversion. It then waits for the converter's end-of-conversion line (`int_n_i`) to go low, drives read low for a fixed time, and captures the data bus at the edge where read returns high. In read-start sequencing a single read falling edge starts the conversion. The converter pulls its ready line low and holds it low until the result is ready. The controller keeps read low all that time and captures the bus as read rises, which happens only after ready has been seen low and then high again.

Both handshake inputs are resynchronised before use. A watchdog counter bounds every wait phase. After each transaction, chip select is released for a minimum gap before the next request is accepted.

Top module: `adc_strobe_host`

## Requirements
- R1: After reset, `cs_n_o`, `wr_n_o` and `rd_n_o` are high, `valid_o` and `err_o` are low, and `idle_o` is high.
- R2: When a request with `mode_rd_i`=0 is taken in idle, `cs_n_o` and `wr_n_o` go low at the next rising edge. `wr_n_o` stays low for exactly WR_PULSE cycles, and `rd_n_o` stays high during that time.
- R3: In write-start sequencing, `rd_n_o` stays high until the interrupt line is low. It falls, with `cs_n_o` still low, at the (SYNC_STAGES+1)-th rising edge after `int_n_i` falls.
- R4: In write-start sequencing, `rd_n_o` stays low for exactly RD_PULSE cycles. At the edge where it rises, `data_o` takes the bus value and `valid_o` is high for exactly one cycle.
- R5: When a request with `mode_rd_i`=1 is taken in idle, `cs_n_o` and `rd_n_o` fall together at the next rising edge, and `wr_n_o` stays high for the whole transaction.
- R6: In read-start sequencing, `rd_n_o` stays low for as long as ready has not yet been seen low and then high. It rises at the (SYNC_STAGES+1)-th edge after `rdy_i` returns high. At that edge `data_o` takes the value on the bus after ready's release, and `valid_o` pulses for one cycle.
- R7: If the interrupt line does not fall, or the ready line does not fall or does not return high, within TIMEOUT cycles of entering that wait, all three strobes go high, `err_o` pulses for one cycle and `valid_o` stays low.
- R8: After read rises, or after an abort, `cs_n_o` stays high and `idle_o` stays low for exactly IDLE_GAP cycles before the controller is idle again.
- R9: A request asserted while `idle_o` is low is ignored: no strobe falls because of it, and the controller remains idle afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Acquisition request, taken only while idle |
| mode_rd_i | input | 1 | 0: write-start sequencing, 1: read-start sequencing |
| idle_o | output | 1 | Controller can take a request |
| valid_o | output | 1 | One-cycle pulse with a new captured byte |
| data_o | output | DATA_W | Last captured byte |
| err_o | output | 1 | One-cycle pulse on a watchdog abort |
| cs_n_o | output | 1 | Converter chip select, active low |
| wr_n_o | output | 1 | Converter write strobe, active low |
| rd_n_o | output | 1 | Converter read strobe, active low |
| int_n_i | input | 1 | Converter end-of-conversion line, active low, asynchronous |
| rdy_i | input | 1 | Converter ready line, low while busy, asynchronous |
| db_i | input | DATA_W | Converter data bus |

## Verification
Every strobe is a flop loaded from the next state, so a strobe changes one rising edge after the decision. A response on `int_n_i` or `rdy_i` reaches the strobes SYNC_STAGES+1 edges after it happens. The bench changes inputs at falling edges and counts falling edges until an output changes. It compares each count with an arithmetic value: WR_PULSE, RD_PULSE, IDLE_GAP, SYNC_STAGES+1, TIMEOUT, or TIMEOUT+SYNC_STAGES+1 for an abort while waiting for ready to release. The captured byte and the valid pulse are checked at the same falling edge where read is first seen high. The sweep covers all 256 byte values, alternates the two sequences and varies the response delays.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WRLO  = 3'd1,
      ST_INTW  = 3'd2,
      ST_RDP   = 3'd3,
      ST_RDYLO = 3'd4,
      ST_RDYHI = 3'd5,
      ST_GAP   = 3'd6
   } host_st_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_host_sync.sv
module adc_host_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   localparam int CHAIN_W = STAGES * WIDTH;

   logic [CHAIN_W-1:0] chain_q;

   if (STAGES < 1 || WIDTH < 1) begin : g_bad_cfg
      $error("adc_host_sync: STAGES and WIDTH must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= RST_VAL;
         else        chain_q <= d_i;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= {STAGES{RST_VAL}};
         else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d_i};
      end
   end

   assign q_o = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/adc_host_timer.sv
module adc_host_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   output logic [CNT_W-1:0] cnt_o
);

   if (CNT_W < 1) begin : g_bad_cfg
      $error("adc_host_timer: CNT_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_o <= '0;
      else if (clear_i)         cnt_o <= '0;
      else if (cnt_o != '1)     cnt_o <= cnt_o + 1'b1;
   end

endmodule

// File: rtl/adc_strobe_host.sv
module adc_strobe_host
   import adc_host_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int WR_PULSE    = 4,
   parameter int RD_PULSE    = 3,
   parameter int TIMEOUT     = 4096,
   parameter int IDLE_GAP    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              mode_rd_i,
   output logic              idle_o,
   output logic              valid_o,
   output logic [DATA_W-1:0] data_o,
   output logic              err_o,
   output logic              cs_n_o,
   output logic              wr_n_o,
   output logic              rd_n_o,
   input  logic              int_n_i,
   input  logic              rdy_i,
   input  logic [DATA_W-1:0] db_i
);

   localparam int MAX_LIM = max2(max2(WR_PULSE, RD_PULSE), max2(TIMEOUT, IDLE_GAP));
   localparam int CNT_W   = $clog2(MAX_LIM + 1);
   localparam logic [CNT_W-1:0] WR_LAST  = CNT_W'(WR_PULSE - 1);
   localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_PULSE - 1);
   localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(TIMEOUT - 1);
   localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(IDLE_GAP - 1);

   if (DATA_W < 1 || WR_PULSE < 1 || RD_PULSE < 1 || TIMEOUT < 2 ||
       IDLE_GAP < 1 || SYNC_STAGES < 2) begin : g_bad_cfg
      $error("adc_strobe_host: parameter out of range");
   end

   host_st_e          state_q, state_d;
   logic [CNT_W-1:0]  cnt;
   logic              int_s, rdy_s;
   logic              cap, tmo, clr;

   // both handshake lines share one resynchroniser
   adc_host_sync #(
      .WIDTH   (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (2'b11)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({int_n_i, rdy_i}),
      .q_o   ({int_s, rdy_s})
   );

   // cycles spent in the current state
   assign clr = (state_d != state_q) || (state_q == ST_IDLE);

   adc_host_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clr),
      .cnt_o   (cnt)
   );

   always_comb begin
      state_d = state_q;
      cap     = 1'b0;
      tmo     = 1'b0;
      unique case (state_q)
         ST_IDLE:  if (req_i) state_d = mode_rd_i ? ST_RDYLO : ST_WRLO;
         ST_WRLO:  if (cnt == WR_LAST) state_d = ST_INTW;
         ST_INTW: begin
            if (!int_s)              state_d = ST_RDP;
            else if (cnt == TO_LAST) begin tmo = 1'b1; state_d = ST_GAP; end
         end
         ST_RDP: if (cnt == RD_LAST) begin cap = 1'b1; state_d = ST_GAP; end
         ST_RDYLO: begin
            if (!rdy_s)              state_d = ST_RDYHI;
            else if (cnt == TO_LAST) begin tmo = 1'b1; state_d = ST_GAP; end
         end
         ST_RDYHI: begin
            if (rdy_s)               begin cap = 1'b1; state_d = ST_GAP; end
            else if (cnt == TO_LAST) begin tmo = 1'b1; state_d = ST_GAP; end
         end
         ST_GAP:  if (cnt == GAP_LAST) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cs_n_o  <= 1'b1;
         wr_n_o  <= 1'b1;
         rd_n_o  <= 1'b1;
         valid_o <= 1'b0;
         err_o   <= 1'b0;
         data_o  <= '0;
      end else begin
         state_q <= state_d;
         cs_n_o  <= (state_d == ST_IDLE) || (state_d == ST_GAP);
         wr_n_o  <= (state_d != ST_WRLO);
         rd_n_o  <= !((state_d == ST_RDP) || (state_d == ST_RDYLO) || (state_d == ST_RDYHI));
         valid_o <= cap;
         err_o   <= tmo;
         if (cap) data_o <= db_i;
      end
   end

   assign idle_o = (state_q == ST_IDLE);

   AST_WR_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n_o |-> !cs_n_o);                                            // R2
   AST_RD_WAITS_INT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_INTW && int_s) |=> rd_n_o);                      // R3
   AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);                                          // R4
   AST_RD_RISE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_n_o) |-> (valid_o || err_o));                          // R4
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n_o |-> rd_n_o);                                            // R5
   AST_ERR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!valid_o && cs_n_o && rd_n_o && wr_n_o));            // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt != '1);                                                     // R7
   AST_BUSY_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n_o |-> !idle_o);                                           // R9

endmodule

// File: tb/adc_strobe_host_tb.sv
`timescale 1ns/1ps
module adc_strobe_host_tb;

   localparam int DW   = 8;
   localparam int WRP  = 3;
   localparam int RDP  = 2;
   localparam int TO   = 40;
   localparam int GAP  = 4;
   localparam int SYN  = 2;
   localparam int LAT  = SYN + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0, mode = 1'b0;
   logic          int_n = 1'b1, rdy = 1'b1;
   logic [DW-1:0] db = '0;
   logic          idle_o, valid_o, err_o, cs_n_o, wr_n_o, rd_n_o;
   logic [DW-1:0] data_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   adc_strobe_host #(
      .DATA_W(DW), .WR_PULSE(WRP), .RD_PULSE(RDP),
      .TIMEOUT(TO), .IDLE_GAP(GAP), .SYNC_STAGES(SYN)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .mode_rd_i(mode),
      .idle_o(idle_o), .valid_o(valid_o), .data_o(data_o), .err_o(err_o),
      .cs_n_o(cs_n_o), .wr_n_o(wr_n_o), .rd_n_o(rd_n_o),
      .int_n_i(int_n), .rdy_i(rdy), .db_i(db)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // from the edge that ended a transaction: gap length, optional ignored request
   task automatic gap_phase(input bit poke);
      int n = 0;
      if (poke) req = 1'b1;
      while (!idle_o && n < 100) begin
         chk(cs_n_o == 1'b1, "R8 cs high in gap", cs_n_o, 1);
         @(negedge clk);
         req = 1'b0;
         n++;
         if (n == 1) chk(valid_o == 1'b0 && err_o == 1'b0, "R4 one-cycle pulse", valid_o, 0);
      end
      chk(n == GAP, "R8 gap length", n, GAP);
      if (poke) begin
         for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(cs_n_o && wr_n_o && rd_n_o && idle_o, "R9 request ignored", cs_n_o, 1);
         end
      end
   endtask

   task automatic wr_txn(input logic [DW-1:0] val, input int conv, input bit poke);
      int n;
      db = ~val; mode = 1'b0; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      chk(!cs_n_o && !wr_n_o && rd_n_o, "R2 start strobes", {cs_n_o, wr_n_o, rd_n_o}, 3'b001);
      n = 0;
      while (!wr_n_o && n < 100) begin
         if (!rd_n_o) chk(0, "R2 read during write", 0, 1);
         n++;
         @(negedge clk);
      end
      chk(n == WRP, "R2 write width", n, WRP);
      for (int i = 0; i < conv; i++) begin
         chk(rd_n_o && !cs_n_o, "R3 read waits for interrupt", rd_n_o, 1);
         @(negedge clk);
      end
      int_n = 1'b0; db = val;
      n = 0;
      do begin @(negedge clk); n++; end while (rd_n_o && n < 50);
      chk(n == LAT, "R3 interrupt to read latency", n, LAT);
      chk(!cs_n_o, "R3 cs low with read", cs_n_o, 0);
      int_n = 1'b1;
      n = 0;
      while (!rd_n_o && n < 50) begin n++; @(negedge clk); end
      chk(n == RDP, "R4 read width", n, RDP);
      chk(valid_o == 1'b1, "R4 valid at read rise", valid_o, 1);
      chk(data_o == val, "R4 captured byte", data_o, val);
      gap_phase(poke);
   endtask

   task automatic rd_txn(input logic [DW-1:0] val, input int lo_dly, input int hi_dly, input bit poke);
      int n;
      db = ~val; mode = 1'b1; req = 1'b1;
      @(negedge clk);
      req = 1'b0; mode = 1'b0;
      chk(!cs_n_o && !rd_n_o && wr_n_o, "R5 start strobes", {cs_n_o, wr_n_o, rd_n_o}, 3'b010);
      for (int i = 0; i < lo_dly; i++) begin
         @(negedge clk);
         chk(!rd_n_o && wr_n_o, "R6 read held before ready falls", rd_n_o, 0);
      end
      rdy = 1'b0;
      for (int i = 0; i < hi_dly; i++) begin
         @(negedge clk);
         chk(!rd_n_o && wr_n_o, "R6 read held while ready low", rd_n_o, 0);
      end
      rdy = 1'b1; db = val;
      n = 0;
      do begin
         @(negedge clk); n++;
         if (!wr_n_o) chk(0, "R5 write stays high", 0, 1);
      end while (!rd_n_o && n < 50);
      chk(n == LAT, "R6 ready to read-rise latency", n, LAT);
      chk(valid_o == 1'b1, "R6 valid at read rise", valid_o, 1);
      chk(data_o == val, "R6 captured new byte", data_o, val);
      gap_phase(poke);
   endtask

   task automatic wait_err(input int exp, input string tag);
      int n = 0;
      while (!err_o && n < 300) begin @(negedge clk); n++; end
      chk(n == exp, tag, n, exp);
      chk(cs_n_o && wr_n_o && rd_n_o && !valid_o, "R7 strobes released", {cs_n_o, wr_n_o, rd_n_o}, 3'b111);
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n_o && wr_n_o && rd_n_o, "R1 strobes high", {cs_n_o, wr_n_o, rd_n_o}, 3'b111);
      chk(!valid_o && !err_o, "R1 pulses low", {valid_o, err_o}, 0);
      chk(idle_o == 1'b1, "R1 idle", idle_o, 1);

      // abort while waiting for the interrupt
      mode = 1'b0; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      n = 0;
      while (!wr_n_o && n < 100) begin n++; @(negedge clk); end
      wait_err(TO, "R7 interrupt timeout");
      gap_phase(1'b0);

      // abort while waiting for ready to fall
      mode = 1'b1; req = 1'b1;
      @(negedge clk);
      req = 1'b0; mode = 1'b0;
      wait_err(TO, "R7 ready-low timeout");
      gap_phase(1'b0);

      // abort while waiting for ready to release
      mode = 1'b1; req = 1'b1;
      @(negedge clk);
      req = 1'b0; mode = 1'b0; rdy = 1'b0;
      wait_err(TO + LAT, "R7 ready-high timeout");
      rdy = 1'b1;
      gap_phase(1'b1);

      // sweep: every byte value, alternating sequences and delays
      for (int v = 0; v < 256; v++) begin
         if (v % 2 == 0) wr_txn(DW'(v), v % 7, (v % 16) == 0);
         else            rd_txn(DW'(v), (v >> 1) % 4, 1 + (v >> 3) % 4, (v % 16) == 1);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog R1..all act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule